// File: doc/BRIEF.md
# DMA Interrupt Request Steering Unit

This unit sits between a set of internal peripheral event lines and two consumers: a four-channel DMA controller and the interrupt path that leads to the CPU or to an event-driven transfer engine. Each channel latches a pending flag when its selected event rises. Two per-channel control bits decide what happens to that flag. The transfer-enable bit decides whether the flag requests a DMA transfer. The acknowledge-enable bit decides whether a finished transfer consumes the flag and keeps it hidden from the CPU, or whether the flag stays pending and interrupts the CPU alongside the transfer.

Software sets up the unit through a single 16-bit control register. The DMA controller answers each request with a one-cycle transfer-done pulse on the matching channel. The CPU side removes a pending flag with a clear strobe. One extra control bit selects single-address operation for the second channel. An input that indicates full-address operation overrides this bit.

Top module: `dmairq_steer`

## Requirements
- R1: After synchronous reset the control register reads 0x0000, and every dma_req, irq_out and ch1_single output is 0.
- R2: A write to the control register shows on cfg_rdata in the cycle after the write edge. Bits 3:0 are transfer-enable for channels 0..3 and bits 11:8 are acknowledge-enable for channels 0..3 (channel 0 at the low bit). Bit 12 is single-address mode for channel 1. All other bits read as 0.
- R3: A pending flag is set only by a 0-to-1 transition of its evt_in line. A line that is held high does not set the flag again after the flag has been cleared.
- R4: dma_req[i] is 1 exactly while channel i is pending and its transfer-enable is 1. It rises in the cycle after the event edge is sampled.
- R5: With transfer-enable=1 and acknowledge-enable=1, a dma_done pulse clears the pending flag, and dma_req drops in the cycle after the pulse.
- R6: With transfer-enable=1 and acknowledge-enable=1, irq_out for that channel stays 0 even while the channel is pending.
- R7: With transfer-enable=1 and acknowledge-enable=0, dma_done leaves the flag pending, dma_req stays high and irq_out is 1. Only cpu_clr clears the flag.
- R8: With transfer-enable=0, irq_out follows the pending flag whatever acknowledge-enable holds, and dma_done has no effect on the flag.
- R9: If an event edge and a clear (cpu_clr or an acknowledged dma_done) reach the same channel in the same cycle, the flag ends up set.
- R10: irq_out is registered. It changes one cycle after the pending flag or the control bits change.
- R11: ch1_single equals control bit 12 while full_addr_mode is 0, and is 0 while full_addr_mode is 1. cfg_rdata still shows the written bit 12 in either case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read-back |
| full_addr_mode | input | 1 | DMA controller runs full-address transfers |
| ch1_single | output | 1 | Effective single-address select for channel 1 |
| evt_in | input | 4 | Per-channel peripheral event lines |
| cpu_clr | input | 4 | Per-channel CPU-side clear strobes |
| dma_done | input | 4 | Per-channel transfer-done pulses |
| dma_req | output | 4 | Per-channel DMA transfer requests |
| irq_out | output | 4 | Per-channel interrupt requests to CPU / event engine |

## Verification
The bench walks every combination of the two enables across channels together with done and clear strobes. A design that swapped the meaning of acknowledge-enable would leak interrupts in the consumed mode or lose them in the parallel mode. A design that let dma_done clear a channel whose transfer-enable is 0 would drop interrupts in the CPU-only mode. The bench sends an event edge and a clear in the same cycle, which exposes a clear-wins priority as a lost event. It holds an event line high across a clear, which exposes level-sensitive setting as a re-armed request. It samples irq_out in the cycle the flag rises, which catches an unregistered output. The full-address override is checked against the read-back, so a design that zeroed the stored bit instead of masking it would fail.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int CH_N   = 4;
    localparam int REG_W  = 16;
    localparam int TE_LSB = 0;
    localparam int AE_LSB = 8;
    localparam int SA_BIT = 12;

    typedef struct packed {
        logic            single_1;
        logic [CH_N-1:0] ack_en;
        logic [CH_N-1:0] xfer_en;
    } steer_cfg_t;

    localparam logic [REG_W-1:0] CFG_MASK =
        REG_W'(((1 << CH_N) - 1) << TE_LSB) |
        REG_W'(((1 << CH_N) - 1) << AE_LSB) |
        REG_W'(1 << SA_BIT);

    function automatic steer_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        steer_cfg_t c;
        c.xfer_en  = w[TE_LSB +: CH_N];
        c.ack_en   = w[AE_LSB +: CH_N];
        c.single_1 = w[SA_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input steer_cfg_t c);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[TE_LSB +: CH_N]  = c.xfer_en;
        w[AE_LSB +: CH_N]  = c.ack_en;
        w[SA_BIT]          = c.single_1;
        return w;
    endfunction

endpackage

// File: rtl/dmairq_cfg_reg.sv
module dmairq_cfg_reg
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             full_addr_mode,
    output steer_cfg_t       cfg,
    output logic [REG_W-1:0] rdata,
    output logic             single_eff
);

    steer_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (we)
            cfg_q <= unpack_cfg(wdata);
    end

    assign cfg        = cfg_q;
    assign rdata      = pack_cfg(cfg_q);
    assign single_eff = cfg_q.single_1 & ~full_addr_mode;

    // R2
    cfg_readback_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata == ($past(wdata) & CFG_MASK)));

endmodule

// File: rtl/dmairq_edge.sv
module dmairq_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= 1'b0;
        else
            lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/dmairq_chan.sv
module dmairq_chan (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic te,
    input  logic ae,
    input  logic done,
    input  logic clr,
    output logic pend,
    output logic req,
    output logic irq
);

    logic rise;
    logic consume;
    logic clr_eff;
    logic pend_q;
    logic irq_q;

    dmairq_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (evt),
        .rise (rise)
    );

    assign consume = te & ae;
    assign clr_eff = clr | (done & consume);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= rise | (pend_q & ~clr_eff);
            irq_q  <= pend_q & ~consume;
        end
    end

    assign pend = pend_q;
    assign req  = pend_q & te;
    assign irq  = irq_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend);

    // R5
    auto_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && te && ae && !rise) |=> !pend);

    // R7
    keep_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !(te && ae) && !clr) |=> pend);

    // R6
    hidden_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (te && ae) |=> !irq);

    // R10
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> !irq);

endmodule

// File: rtl/dmairq_steer.sv
module dmairq_steer
    import dmairq_pkg::*;
#(
    parameter int N_CH  = CH_N,
    parameter int CFG_W = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             full_addr_mode,
    output logic             ch1_single,
    input  logic [N_CH-1:0]  evt_in,
    input  logic [N_CH-1:0]  cpu_clr,
    input  logic [N_CH-1:0]  dma_done,
    output logic [N_CH-1:0]  dma_req,
    output logic [N_CH-1:0]  irq_out
);

    steer_cfg_t      cfg;
    logic [N_CH-1:0] pend;

    dmairq_cfg_reg u_cfg (
        .clk            (clk),
        .rst            (rst),
        .we             (cfg_we),
        .wdata          (cfg_wdata),
        .full_addr_mode (full_addr_mode),
        .cfg            (cfg),
        .rdata          (cfg_rdata),
        .single_eff     (ch1_single)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        dmairq_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt_in[i]),
            .te   (cfg.xfer_en[i]),
            .ae   (cfg.ack_en[i]),
            .done (dma_done[i]),
            .clr  (cpu_clr[i]),
            .pend (pend[i]),
            .req  (dma_req[i]),
            .irq  (irq_out[i])
        );
    end

endmodule

// File: tb/tb_dmairq_steer.sv
module tb_dmairq_steer;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;
    localparam int NV         = 8;

    // fields, 4 bits each, high to low:
    // te, ae, done, clr, req_after_evt, irq_after_evt, req_after_strobe, irq_after_strobe
    localparam logic [31:0] VEC [NV] = '{
        32'h00F0_0F0F,  // R8 CPU-only, done ignored
        32'hFFF0_F000,  // R5 R6 consumed by DMA
        32'hF0F0_FFFF,  // R7 parallel, done keeps flag
        32'hF00F_FF00,  // R7 parallel, cpu clear
        32'h0FF0_0F0F,  // R8 ack-enable without transfer-enable
        32'h35F4_3E2A,  // mixed
        32'hCA61_C7C6,  // mixed
        32'h9910_9686   // mixed
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        full_addr_mode = 1'b0;
    logic        ch1_single;
    logic [3:0]  evt_in = '0;
    logic [3:0]  cpu_clr = '0;
    logic [3:0]  dma_done = '0;
    logic [3:0]  dma_req;
    logic [3:0]  irq_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    dmairq_steer dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .full_addr_mode (full_addr_mode),
        .ch1_single     (ch1_single),
        .evt_in         (evt_in),
        .cpu_clr        (cpu_clr),
        .dma_done       (dma_done),
        .dma_req        (dma_req),
        .irq_out        (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [15:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        evt_in   = '0;
        dma_done = '0;
        cpu_clr  = 4'hF;
        @(negedge clk);
        cpu_clr  = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        after_edge();
        // R1
        check("R1 cfg_rdata", cfg_rdata, 16'h0000);
        check("R1 dma_req", {12'h0, dma_req}, 16'h0);
        check("R1 irq_out", {12'h0, irq_out}, 16'h0);
        check("R1 ch1_single", {15'h0, ch1_single}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] te, ae, dn, cl, re, ie, ra, ia;
            {te, ae, dn, cl, re, ie, ra, ia} = VEC[i];
            flush();
            cfg_we    = 1'b1;
            cfg_wdata = {4'b0, ae, 4'b0, te};
            @(negedge clk);
            cfg_we    = 1'b0;
            evt_in    = 4'hF;
            after_edge();
            check("R4 req after event", {12'h0, dma_req}, {12'h0, re});
            @(negedge clk);
            evt_in = '0;
            after_edge();
            check("R6 R8 irq after event", {12'h0, irq_out}, {12'h0, ie});
            @(negedge clk);
            dma_done = dn;
            cpu_clr  = cl;
            after_edge();
            check("R5 R7 req after strobes", {12'h0, dma_req}, {12'h0, ra});
            @(negedge clk);
            dma_done = '0;
            cpu_clr  = '0;
            after_edge();
            check("R7 R8 irq after strobes", {12'h0, irq_out}, {12'h0, ia});
        end

        // R2 reserved bits read 0
        write_cfg(16'hFFFF);
        #1;
        check("R2 readback mask", cfg_rdata, 16'h1F0F);
        // R11 override
        check("R11 single when not full", {15'h0, ch1_single}, 16'h1);
        full_addr_mode = 1'b1;
        #1;
        check("R11 single masked", {15'h0, ch1_single}, 16'h0);
        check("R11 readback keeps bit", cfg_rdata, 16'h1F0F);
        @(negedge clk);
        full_addr_mode = 1'b0;

        // R9 set beats clear, te=ae=1
        flush();
        evt_in   = 4'b0001;
        dma_done = 4'b0001;
        cpu_clr  = 4'b0001;
        after_edge();
        check("R9 set wins", {12'h0, dma_req}, 16'h0001);
        // R3 held level does not re-arm
        @(negedge clk);
        dma_done = '0;
        cpu_clr  = 4'b0001;
        after_edge();
        check("R3 cleared under high level", {12'h0, dma_req}, 16'h0000);
        @(negedge clk);
        cpu_clr = '0;
        after_edge();
        check("R3 no re-arm on level", {12'h0, dma_req}, 16'h0000);
        @(negedge clk);
        evt_in = '0;
        @(negedge clk);
        evt_in = 4'b0001;
        after_edge();
        check("R3 new rise sets", {12'h0, dma_req}, 16'h0001);

        // R10 irq one cycle behind flag
        write_cfg(16'h0000);
        flush();
        evt_in = 4'b0010;
        after_edge();
        check("R10 irq not yet", {12'h0, irq_out}, 16'h0000);
        @(negedge clk);
        evt_in = '0;
        after_edge();
        check("R10 irq next cycle", {12'h0, irq_out}, 16'h0002);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule